// File: doc/BRIEF.md
# Prioritized DMA Channel Control Bank

This block is the per-channel control state of a DMA controller with up to a dozen channels. Software reaches it through a small single-cycle register port. Each per-channel bit vector is changed through a pair of write aliases: one sets the written ones and one clears them. The vectors are channel enable, descriptor alternate-select, high priority, burst use, request mask, completion flag and interrupt enable. Writing a one affects only that channel. Bits written as zero keep their value.

Completion inputs from the data path retire a channel. A done pulse on an enabled channel clears its enable and raises its completion flag. A bus error input raises an error flag that sits in the flag vector just above the channel bits. A pending interrupt is a flag that is also enabled. A completion arbiter picks the channel to service. It takes pending high-priority channels first, lowest index first. Default-priority channels are considered only when no high-priority channel is pending. The arbiter result is registered once per clock into a channel number and a valid flag. An interrupt line is raised whenever anything is pending, including the error.

Peripheral requests pass to the data path only when the controller is on, the channel is enabled and its mask bit is clear.

Top module: `dma_chan_bank`

## Requirements
- R1: Address codes: 0 control (bit 0 = controller on, read/write), 1/2 enable set/clear, 3/4 alternate set/clear, 5/6 priority set/clear, 7/8 burst set/clear, 9/10 mask set/clear, 11/12 flag set/clear, 13/14 interrupt-enable set/clear. Bit i of a vector is channel i. Writing a 1 to a set (clear) address sets (clears) only that bit, and zeros leave bits unchanged.
- R2: When a bit is set and cleared in the same cycle, for example a done pulse arriving together with an enable-set write, or with a flag-clear write, the clear wins.
- R3: A done pulse on an enabled channel clears its enable bit and sets its completion flag at the next clock edge. A done pulse on a disabled channel does nothing.
- R4: Reading either address of a pair returns the current vector. Reading address 1 returns the enable state.
- R5: A pending interrupt is flag AND interrupt-enable. `irq_o` is registered and is high one cycle after anything is pending, including the error bit.
- R6: The arbiter selects the lowest-index pending high-priority channel if there is one.
- R7: With no high-priority channel pending, the arbiter selects the lowest-index pending default-priority channel. `irq_vld_o` is low when no channel is pending. Outputs are registered one cycle after the pending vector changes.
- R8: `bus_err_i` sets the flag bit at position NUM_CH. Writing a 1 to that bit at the flag-clear address clears it.
- R9: After reset, every vector, the control bit, the flags, the error flag and all outputs are zero.
- R10: `req_o[i]` = `req_i[i]` only when the controller is on, channel i is enabled and its mask bit is clear. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| done_i | input | NUM_CH | Per-channel completion pulses |
| bus_err_i | input | 1 | Bus error pulse |
| req_i | input | NUM_CH | Peripheral requests |
| req_o | output | NUM_CH | Gated requests to the data path |
| alt_o | output | NUM_CH | Alternate-select state |
| burst_o | output | NUM_CH | Burst-use state |
| irq_o | output | 1 | Interrupt, any pending source |
| irq_vld_o | output | 1 | A channel is selected |
| irq_ch_o | output | 4 | Selected channel number |

## Verification
Two functions can act in the same cycle on the same channel bit. A completion pulse can arrive together with a software write to that channel's enable-set address. It can also arrive together with a write to the flag-clear address. The bench provokes each collision by driving the done pulse and the write in the same clock. It then reads the vector back through the set address. It expects the bit to be zero, because the clear wins. A second overlap is checked as well: flag changes and priority changes made while other channels stay pending. The arbiter must re-pick from the new vector exactly one cycle later.

// File: rtl/dma_bank_pkg.sv
package dma_bank_pkg;

  typedef enum logic [3:0] {
    A_CTRL   = 4'd0,
    A_EN_S   = 4'd1,  A_EN_C   = 4'd2,
    A_ALT_S  = 4'd3,  A_ALT_C  = 4'd4,
    A_PRI_S  = 4'd5,  A_PRI_C  = 4'd6,
    A_BST_S  = 4'd7,  A_BST_C  = 4'd8,
    A_MSK_S  = 4'd9,  A_MSK_C  = 4'd10,
    A_FLG_S  = 4'd11, A_FLG_C  = 4'd12,
    A_IEN_S  = 4'd13, A_IEN_C  = 4'd14
  } reg_addr_e;

  // Index of the lowest set bit (0 when empty).
  function automatic logic [4:0] lowest_idx(input logic [31:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = 5'(i);
    end
    return r;
  endfunction

  // Group that the arbiter draws from: high-priority pending if any.
  function automatic logic [31:0] service_group(input logic [31:0] pend,
                                                input logic [31:0] hi);
    logic [31:0] h;
    h = pend & hi;
    return (|h) ? h : (pend & ~hi);
  endfunction

endpackage

// File: rtl/dma_setclr_vec.sv
module dma_setclr_vec #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_v,
  input  logic [W-1:0] clr_v,
  output logic [W-1:0] q
);

  logic [W-1:0] both_w;
  assign both_w = set_v & clr_v;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q | set_v) & ~clr_v;
  end

  p_clear_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|both_w) |=> ((q & $past(both_w)) == '0));

  p_set_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_v & ~clr_v)) |=> ((q & $past(set_v & ~clr_v)) == $past(set_v & ~clr_v)));

  p_untouched_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((q ^ $past(q)) & ~$past(set_v | clr_v)) == '0));

endmodule

// File: rtl/dma_irq_arb.sv
module dma_irq_arb
  import dma_bank_pkg::*;
#(
  parameter int NUM_CH = 12,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pend,
  input  logic [NUM_CH-1:0] hi,
  input  logic              err_pend,
  output logic              irq_o,
  output logic              vld_o,
  output logic [CH_W-1:0]   ch_o
);

  logic [31:0]       grp_w;
  logic [4:0]        idx_w;
  logic [NUM_CH-1:0] pend_q, hi_q, lower_m;

  assign grp_w = service_group(32'(pend), 32'(hi));
  assign idx_w = lowest_idx(grp_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o  <= 1'b0;
      vld_o  <= 1'b0;
      ch_o   <= '0;
      pend_q <= '0;
      hi_q   <= '0;
    end else begin
      irq_o  <= (|pend) | err_pend;
      vld_o  <= |pend;
      ch_o   <= CH_W'(idx_w);
      pend_q <= pend;
      hi_q   <= hi;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) lower_m[i] = (i < int'(ch_o));
  end

  p_hi_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && |(pend_q & hi_q)) |-> (hi_q[ch_o] && pend_q[ch_o]));

  p_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (pend_q[ch_o] &&
               ((pend_q & (hi_q[ch_o] ? hi_q : ~hi_q) & lower_m) == '0)));

  p_vld_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> irq_o);

endmodule

// File: rtl/dma_chan_bank.sv
module dma_chan_bank
  import dma_bank_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int DATA_W = 32,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int FLG_W = NUM_CH + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [3:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_CH-1:0] done_i,
  input  logic              bus_err_i,
  input  logic [NUM_CH-1:0] req_i,
  output logic [NUM_CH-1:0] req_o,
  output logic [NUM_CH-1:0] alt_o,
  output logic [NUM_CH-1:0] burst_o,
  output logic              irq_o,
  output logic              irq_vld_o,
  output logic [CH_W-1:0]   irq_ch_o
);

  // Per-address write strobe, one bit per address code.
  logic [15:0] wr_hit;
  always_comb begin
    wr_hit = '0;
    if (reg_wen) wr_hit[reg_addr] = 1'b1;
  end

  logic [NUM_CH-1:0] wd_ch;
  logic [FLG_W-1:0]  wd_fl;
  logic              unused_wdata;
  assign wd_ch = reg_wdata[NUM_CH-1:0];
  assign wd_fl = reg_wdata[FLG_W-1:0];
  assign unused_wdata = ^reg_wdata[DATA_W-1:FLG_W];

  logic [NUM_CH-1:0] en_q, alt_q, pri_q, bst_q, msk_q;
  logic [FLG_W-1:0]  flg_q, ien_q;
  logic              ctrl_on_q;

  // Completion on an enabled channel: the retire event.
  logic [NUM_CH-1:0] done_eff;
  assign done_eff = done_i & en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             ctrl_on_q <= 1'b0;
    else if (wr_hit[A_CTRL]) ctrl_on_q <= reg_wdata[0];
  end

  // Channel-width vectors: enable, alternate, priority, burst, mask.
  logic [4:0][NUM_CH-1:0] cv_set, cv_clr, cv_q;
  always_comb begin
    for (int k = 0; k < 5; k++) begin
      cv_set[k] = wr_hit[2*k+1] ? wd_ch : '0;
      cv_clr[k] = wr_hit[2*k+2] ? wd_ch : '0;
    end
    cv_clr[0] = cv_clr[0] | done_eff;
  end

  for (genvar k = 0; k < 5; k++) begin : g_chvec
    dma_setclr_vec #(.W(NUM_CH)) u_vec (
      .clk(clk), .rst_n(rst_n),
      .set_v(cv_set[k]), .clr_v(cv_clr[k]), .q(cv_q[k])
    );
  end

  assign en_q  = cv_q[0];
  assign alt_q = cv_q[1];
  assign pri_q = cv_q[2];
  assign bst_q = cv_q[3];
  assign msk_q = cv_q[4];

  // Flag-width vectors: completion/error flags and interrupt enables.
  logic [FLG_W-1:0] fl_set, fl_clr, ie_set, ie_clr;
  assign fl_set = (wr_hit[A_FLG_S] ? wd_fl : '0) | {bus_err_i, done_eff};
  assign fl_clr =  wr_hit[A_FLG_C] ? wd_fl : '0;
  assign ie_set =  wr_hit[A_IEN_S] ? wd_fl : '0;
  assign ie_clr =  wr_hit[A_IEN_C] ? wd_fl : '0;

  dma_setclr_vec #(.W(FLG_W)) u_flag (
    .clk(clk), .rst_n(rst_n), .set_v(fl_set), .clr_v(fl_clr), .q(flg_q)
  );
  dma_setclr_vec #(.W(FLG_W)) u_ien (
    .clk(clk), .rst_n(rst_n), .set_v(ie_set), .clr_v(ie_clr), .q(ien_q)
  );

  logic [FLG_W-1:0] pend_w;
  assign pend_w = flg_q & ien_q;

  dma_irq_arb #(.NUM_CH(NUM_CH)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .pend(pend_w[NUM_CH-1:0]), .hi(pri_q), .err_pend(pend_w[NUM_CH]),
    .irq_o(irq_o), .vld_o(irq_vld_o), .ch_o(irq_ch_o)
  );

  // Read side: both aliases of a pair return the vector.
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:           reg_rdata[0]        = ctrl_on_q;
      A_EN_S,  A_EN_C:  reg_rdata[NUM_CH-1:0] = en_q;
      A_ALT_S, A_ALT_C: reg_rdata[NUM_CH-1:0] = alt_q;
      A_PRI_S, A_PRI_C: reg_rdata[NUM_CH-1:0] = pri_q;
      A_BST_S, A_BST_C: reg_rdata[NUM_CH-1:0] = bst_q;
      A_MSK_S, A_MSK_C: reg_rdata[NUM_CH-1:0] = msk_q;
      A_FLG_S, A_FLG_C: reg_rdata[FLG_W-1:0]  = flg_q;
      A_IEN_S, A_IEN_C: reg_rdata[FLG_W-1:0]  = ien_q;
      default:          reg_rdata = '0;
    endcase
  end

  assign req_o   = ctrl_on_q ? (req_i & en_q & ~msk_q) : '0;
  assign alt_o   = alt_q;
  assign burst_o = bst_q;

  p_done_retires_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_eff) |=> ((en_q & $past(done_eff)) == '0));

  p_done_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|done_eff) && !wr_hit[A_FLG_C])
      |=> ((flg_q[NUM_CH-1:0] & $past(done_eff)) == $past(done_eff)));

  p_err_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err_i && !wr_hit[A_FLG_C]) |=> flg_q[NUM_CH]);

  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_o & (msk_q | ~en_q)) == '0));

endmodule

// File: tb/tb_dma_chan_bank.sv
module tb_dma_chan_bank;
  localparam int N = 12;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [N-1:0] done_i = '0, req_i = '0, req_o, alt_o, burst_o;
  logic        bus_err_i = 1'b0, irq_o, irq_vld_o;
  logic [3:0]  irq_ch_o;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  dma_chan_bank dut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done_i(done_i),
    .bus_err_i(bus_err_i), .req_i(req_i), .req_o(req_o), .alt_o(alt_o),
    .burst_o(burst_o), .irq_o(irq_o), .irq_vld_o(irq_vld_o),
    .irq_ch_o(irq_ch_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // Bench model of the service order.
  function automatic int model_pick(input logic [N-1:0] p, input logic [N-1:0] h);
    for (int i = 0; i < N; i++) if (p[i] && h[i]) return i;
    for (int i = 0; i < N; i++) if (p[i]) return i;
    return -1;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 15; a++) begin
      rd(4'(a), d);
      chk($sformatf("R9 reg %0d after reset", a), d, 0);
    end
    chk("R9 irq after reset", {29'd0, irq_o, irq_vld_o, 1'b0}, 0);
    chk("R9 req_o after reset", 32'(req_o), 0);
  endtask

  task automatic t_setclr();
    logic [31:0] d;
    wr(4'd1, 32'h005); wr(4'd1, 32'h010);
    rd(4'd1, d); chk("R1 R4 enable set accumulates", d, 32'h015);
    wr(4'd2, 32'h001);
    rd(4'd1, d); chk("R1 enable clear one bit", d, 32'h014);
    rd(4'd2, d); chk("R4 clear alias reads vector", d, 32'h014);
    wr(4'd3, 32'h8A0); wr(4'd4, 32'h080);
    @(negedge clk); chk("R1 alternate vector", 32'(alt_o), 32'h820);
    wr(4'd7, 32'h00F); wr(4'd8, 32'h00C);
    @(negedge clk); chk("R1 burst vector", 32'(burst_o), 32'h003);
  endtask

  task automatic t_mask();
    @(negedge clk); req_i = '1;
    #1 chk("R10 controller off blocks requests", 32'(req_o), 0);
    wr(4'd0, 32'h1);
    #1 chk("R10 enabled channels pass", 32'(req_o), 32'h014);
    wr(4'd9, 32'h010);
    #1 chk("R10 masked channel ignored", 32'(req_o), 32'h004);
    wr(4'd10, 32'h010);
    #1 chk("R10 unmask restores", 32'(req_o), 32'h014);
    req_i = '0;
  endtask

  task automatic t_done();
    logic [31:0] d;
    @(negedge clk); done_i = 12'h006;   // ch1 disabled, ch2 enabled
    @(negedge clk); done_i = '0;
    rd(4'd1, d);  chk("R3 done clears enable", d, 32'h010);
    rd(4'd11, d); chk("R3 done sets flag only for enabled", d, 32'h004);
    chk("R5 flag without enable no irq", 32'(irq_o), 0);
    wr(4'd13, 32'h004);
    @(negedge clk);
    chk("R5 irq once enabled", 32'(irq_o), 1);
    chk("R7 single pending channel", {27'd0, irq_vld_o, irq_ch_o}, {27'd0, 1'b1, 4'd2});
    wr(4'd12, 32'h004);
    @(negedge clk);
    chk("R5 flag clear drops irq", {30'd0, irq_o, irq_vld_o}, 0);
  endtask

  task automatic t_arb();
    logic [N-1:0] fl, hi;
    int e;
    wr(4'd13, 32'h1FFF);
    fl = 12'h222; hi = 12'h220;
    wr(4'd11, 32'(fl)); wr(4'd5, 32'(hi));
    @(negedge clk); e = model_pick(fl, hi);
    chk("R6 high priority first", {27'd0, irq_vld_o, irq_ch_o}, {27'd0, 1'b1, 4'(e)});
    wr(4'd12, 32'h020); fl = 12'h202;
    @(negedge clk); e = model_pick(fl, hi);
    chk("R6 next high priority", 32'(irq_ch_o), 32'(e));
    wr(4'd12, 32'h200); fl = 12'h002;
    @(negedge clk); e = model_pick(fl, hi);
    chk("R7 default when no high pending", 32'(irq_ch_o), 32'(e));
    wr(4'd11, 32'h889); fl = 12'h88B;
    @(negedge clk); e = model_pick(fl, hi);
    chk("R7 lowest default index", 32'(irq_ch_o), 32'(e));
    wr(4'd5, 32'h800); hi = 12'hA20;
    @(negedge clk); e = model_pick(fl, hi);
    chk("R6 priority change re-picks", 32'(irq_ch_o), 32'(e));
    wr(4'd12, 32'hFFF); wr(4'd6, 32'hFFF);
    @(negedge clk);
    chk("R7 nothing pending", {30'd0, irq_o, irq_vld_o}, 0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(4'd1, 32'h040);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = 4'd1; reg_wdata = 32'h040; done_i = 12'h040;
    @(negedge clk);
    reg_wen = 1'b0; done_i = '0;
    rd(4'd1, d); chk("R2 done beats enable set", d & 32'h040, 0);
    wr(4'd1, 32'h040);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = 4'd12; reg_wdata = 32'h040; done_i = 12'h040;
    @(negedge clk);
    reg_wen = 1'b0; done_i = '0;
    rd(4'd11, d); chk("R2 flag clear beats done", d & 32'h040, 0);
    rd(4'd1, d);  chk("R3 enable still retired", d & 32'h040, 0);
  endtask

  task automatic t_err();
    logic [31:0] d;
    @(negedge clk); bus_err_i = 1'b1;
    @(negedge clk); bus_err_i = 1'b0;
    rd(4'd11, d); chk("R8 error flag bit 12", d, 32'h1000);
    @(negedge clk);
    chk("R5 error raises irq without channel", {30'd0, irq_o, irq_vld_o}, 32'h2);
    wr(4'd12, 32'h1000);
    rd(4'd11, d); chk("R8 error flag cleared", d, 0);
    @(negedge clk);
    chk("R5 irq drops after error clear", 32'(irq_o), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset(); t_setclr(); t_mask(); t_done();
        t_arb(); t_collide(); t_err();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule